// File: doc/BRIEF.md
# Dirty-Page Modification Logger

This block sits beside a second-stage address translation walker and watches the events that set a page's dirty flag. Each event carries the page's guest physical address and the value the flag held before the update. Only an event whose previous flag was clear is a new modification. For such an event the block writes one 8-byte record into a 4 KB log buffer in memory. The record holds the page address with its low 12 bits forced to zero. Records are placed through a memory write port, and the slot is chosen by a 512-entry index that counts down from the top of the buffer.

Logging covers every mapping, with no range selection, and it runs only while the accessed/dirty tracking enable is set. When a new modification arrives after all 512 slots have been used, the block raises a log-full event and stops taking events. Software drains the buffer and then pulses an index reset. That pulse restores the index to the top slot and clears the full event, and the event that was held is then logged.

Both streams use valid/ready. An event is consumed only in a cycle where `ev_valid` and `ev_ready` are both high. The block holds `ev_ready` low in four cases: while the log-full event is pending, in a cycle where the index reset is asserted, while the write stage holds a record that is not being accepted, and in a cycle where the presented event needs a slot but none is left. On the write port, a record stays on `wr_addr`/`wr_data` with `wr_valid` high until `wr_ready` is seen. Events are never dropped; back-pressure only delays them.

Top module: `dirty_log_top`

## Requirements
- R1: After reset, `log_index` is 511, `log_full` is 0 and `wr_valid` is 0.
- R2: An accepted event with `ev_prev_dirty`=0 while `log_en`=1 puts one record on the write port in the next cycle. Its data is the event address, zero-extended to 64 bits, with bits 11:0 cleared.
- R3: An accepted event with `ev_prev_dirty`=1 produces no record and leaves `log_index` unchanged.
- R4: While `log_en`=0, accepted events produce no record and leave `log_index` unchanged.
- R5: A record's address is the 4 KB-aligned `buf_base` plus 8 times the index value held when the event was accepted. Each logged event lowers `log_index` by one in the next cycle.
- R6: After 512 records, `log_index` reads 10'h3FF (that is, -1) and `log_full` is still 0. The next event needing a record is not accepted, and `log_full` rises in the following cycle.
- R7: While `log_full`=1, `ev_ready` is 0 for every event and no record is produced.
- R8: A cycle with `sw_idx_reset`=1 has `ev_ready`=0. In the next cycle `log_index` is 511 and `log_full` is 0, and the held event is then logged at slot 511.
- R9: While `wr_valid`=1 and `wr_ready`=0, the record stays stable and `ev_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| log_en | input | 1 | Accessed/dirty tracking enable from the root pointer |
| buf_base | input | 64 | Log buffer base address (low 12 bits ignored) |
| sw_idx_reset | input | 1 | Software pulse: index back to 511, full cleared |
| ev_valid | input | 1 | Dirty-update event valid |
| ev_ready | output | 1 | Event accepted this cycle when high with ev_valid |
| ev_prev_dirty | input | 1 | Dirty flag value before this update |
| ev_gpa | input | 52 | Guest physical address of the page |
| wr_valid | output | 1 | Log record write valid |
| wr_ready | input | 1 | Memory accepts the record |
| wr_addr | output | 64 | Byte address of the record slot |
| wr_data | output | 64 | Record: page address, low 12 bits zero |
| log_index | output | 10 | Current index, two's complement (-1 once the buffer is full) |
| log_full | output | 1 | Log-full event pending |

## Verification
The bench presents four kinds of events: fresh modifications, updates to pages that are already dirty, and events of either kind while tracking is disabled. The comparison of record count and index shows whether the filter keys on the old flag and on the enable. Back-to-back fresh events sent while `wr_ready` is held low and pulsed show that records are held and that no event is lost or duplicated. A full run of 512 records followed by one more event separates the exact point where the buffer counts as exhausted from the point where the full event fires. A following index reset shows that the held event lands in the top slot.

// File: rtl/dirty_log_pkg.sv
package dirty_log_pkg;
  localparam int DEF_ADDR_W    = 64;
  localparam int DEF_DATA_W    = 64;
  localparam int DEF_GPA_W     = 52;
  localparam int DEF_ENTRIES   = 512;
  localparam int DEF_REC_BYTES = 8;
  localparam int PAGE_SHIFT    = 12;
endpackage

// File: rtl/dirty_log_filter.sv
module dirty_log_filter (
  input  logic ev_valid,
  input  logic ev_prev_dirty,
  input  logic log_en,
  output logic want_log
);
  // A fresh 0->1 dirty transition needs a slot only while tracking is on.
  always_comb want_log = ev_valid && log_en && !ev_prev_dirty;
endmodule

// File: rtl/dirty_log_index.sv
module dirty_log_index #(
  parameter int ENTRIES = 512,
  localparam int IDX_W  = $clog2(ENTRIES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_load,
  input  logic             dec,
  input  logic             full_req,
  output logic [IDX_W-1:0] idx,
  output logic             wrapped,
  output logic             full
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx  <= TOP;
      full <= 1'b0;
    end else if (sw_load) begin
      idx  <= TOP;
      full <= 1'b0;
    end else begin
      if (full_req) full <= 1'b1;
      if (dec)      idx  <= idx - 1'b1;
    end
  end

  always_comb wrapped = idx[IDX_W-1];

  AST_INDEX_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sw_load |=> (idx == TOP) && !full); // R8
  AST_NO_USE_WRAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    wrapped |-> !dec); // R6
  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !sw_load) |=> idx == $past(idx) - 1'b1); // R5
endmodule

// File: rtl/dirty_log_wstage.sv
module dirty_log_wstage #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              free,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  always_comb free = !wr_valid || wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (load) begin
      wr_valid <= 1'b1;
      wr_addr  <= in_addr;
      wr_data  <= in_data;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  AST_RECORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R9
endmodule

// File: rtl/dirty_log_top.sv
module dirty_log_top
  import dirty_log_pkg::*;
#(
  parameter int ADDR_W    = DEF_ADDR_W,
  parameter int DATA_W    = DEF_DATA_W,
  parameter int GPA_W     = DEF_GPA_W,
  parameter int ENTRIES   = DEF_ENTRIES,
  parameter int REC_BYTES = DEF_REC_BYTES,
  localparam int IDX_W    = $clog2(ENTRIES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              log_en,
  input  logic [ADDR_W-1:0] buf_base,
  input  logic              sw_idx_reset,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic              ev_prev_dirty,
  input  logic [GPA_W-1:0]  ev_gpa,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [IDX_W-1:0]  log_index,
  output logic              log_full
);
  localparam int REC_SHIFT = $clog2(REC_BYTES);
  localparam int BUF_SHIFT = $clog2(ENTRIES * REC_BYTES);
  localparam logic [ADDR_W-1:0] BUF_MASK  = ADDR_W'((64'd1 << BUF_SHIFT) - 1);
  localparam logic [DATA_W-1:0] PAGE_MASK = DATA_W'((64'd1 << PAGE_SHIFT) - 1);

  logic want_log, wrapped, full_q, free, accept, dec, full_req;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] slot_addr;
  logic [DATA_W-1:0] rec_data;

  dirty_log_filter u_filter (
    .ev_valid      (ev_valid),
    .ev_prev_dirty (ev_prev_dirty),
    .log_en        (log_en),
    .want_log      (want_log)
  );

  always_comb begin
    ev_ready = !full_q && !sw_idx_reset && free && !(want_log && wrapped);
    accept   = ev_valid && ev_ready;
    dec      = accept && want_log;
    full_req = want_log && wrapped && !full_q && !sw_idx_reset;
    slot_addr = (buf_base & ~BUF_MASK)
              | (ADDR_W'(idx_q[IDX_W-2:0]) << REC_SHIFT);
    rec_data  = DATA_W'(ev_gpa) & ~PAGE_MASK;
  end

  dirty_log_index #(.ENTRIES(ENTRIES)) u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_load  (sw_idx_reset),
    .dec      (dec),
    .full_req (full_req),
    .idx      (idx_q),
    .wrapped  (wrapped),
    .full     (full_q)
  );

  dirty_log_wstage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wstage (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dec),
    .in_addr  (slot_addr),
    .in_data  (rec_data),
    .free     (free),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  always_comb begin
    log_index = idx_q;
    log_full  = full_q;
  end

  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    log_full |-> !ev_ready); // R7
  AST_STALE_NO_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && (ev_prev_dirty || !log_en)) |=> !wr_valid); // R3
  AST_RECORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data & PAGE_MASK) == '0); // R2
  AST_FULL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(log_full) |-> $past(wrapped)); // R6
  AST_RESET_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    sw_idx_reset |-> !ev_ready); // R8
endmodule

// File: tb/dirty_log_top_tb_top.sv
module dirty_log_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        log_en = 1'b1;
  logic [63:0] buf_base = 64'h0000_0012_3456_7ABC;
  logic        sw_idx_reset = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic        ev_prev_dirty = 1'b0;
  logic [51:0] ev_gpa = '0;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [63:0] wr_addr;
  logic [63:0] wr_data;
  logic [9:0]  log_index;
  logic        log_full;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  int          m_idx = 511;
  bit          m_full = 0;
  bit          m_ov = 0;
  logic [63:0] m_oa = '0, m_od = '0;

  dirty_log_top dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit m_ready(input bit v, input bit pd, input bit sw);
    bit need = v && log_en && !pd;
    return !m_full && !sw && (!m_ov || wr_ready) && !(need && m_idx < 0);
  endfunction

  // one clock: drive at negedge, compare, advance model at posedge
  task automatic cyc(input bit v, input bit pd, input logic [51:0] g, input bit wr, input bit sw);
    bit rdy, need, lg;
    logic [63:0] na;
    ev_valid = v; ev_prev_dirty = pd; ev_gpa = g; wr_ready = wr; sw_idx_reset = sw;
    #1;
    rdy = m_ready(v, pd, sw);
    chk(ev_ready === rdy, "R7/R9 ev_ready", 64'(ev_ready), 64'(rdy));
    chk(wr_valid === m_ov, "R2 wr_valid", 64'(wr_valid), 64'(m_ov));
    if (m_ov) begin
      chk(wr_addr === m_oa, "R5 wr_addr", wr_addr, m_oa);
      chk(wr_data === m_od, "R2 wr_data", wr_data, m_od);
    end
    chk(log_index === 10'(m_idx), "R6 log_index", 64'(log_index), 64'(10'(m_idx)));
    chk(log_full === m_full, "R6 log_full", 64'(log_full), 64'(m_full));
    need = v && log_en && !pd;
    lg = v && rdy && need;
    na = (buf_base & ~64'hFFF) + 64'(m_idx) * 8;
    @(posedge clk);
    if (sw) begin m_idx = 511; m_full = 0; end
    else begin
      if (need && m_idx < 0) m_full = 1;
      if (lg) m_idx--;
    end
    if (lg) begin m_ov = 1; m_oa = na; m_od = 64'(g) & ~64'hFFF; end
    else if (wr) m_ov = 0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(log_index === 10'd511, "R1 reset index", 64'(log_index), 64'd511);
    chk(log_full === 1'b0, "R1 reset full", 64'(log_full), 64'd0);
    chk(wr_valid === 1'b0, "R1 reset wr_valid", 64'(wr_valid), 64'd0);
    @(negedge clk);

    // R2/R5: fresh modifications
    cyc(1, 0, 52'hA_BCDE_F012_3FFF, 1, 0);
    cyc(1, 0, 52'h0_0000_0000_1001, 1, 0);
    cyc(0, 0, 0, 1, 0);
    chk(log_index === 10'd509, "R5 index after two", 64'(log_index), 64'd509);

    // R3: already-dirty pages are not logged
    cyc(1, 1, 52'h1_2345_6789_A000, 1, 0);
    cyc(1, 1, 52'h1_2345_6789_B000, 1, 0);
    chk(log_index === 10'd509, "R3 index unchanged", 64'(log_index), 64'd509);
    chk(wr_valid === 1'b0, "R3 no record", 64'(wr_valid), 64'd0);

    // R4: tracking disabled
    log_en = 1'b0;
    cyc(1, 0, 52'hF_FFFF_FFFF_F000, 1, 0);
    cyc(0, 0, 0, 1, 0);
    chk(log_index === 10'd509, "R4 index unchanged", 64'(log_index), 64'd509);
    chk(wr_valid === 1'b0, "R4 no record", 64'(wr_valid), 64'd0);
    log_en = 1'b1;

    // R9: write back-pressure with back-to-back events
    for (int i = 0; i < 12; i++)
      cyc(1, 0, 52'(64'h5000 + 64'(i) * 64'h1000), (i % 3) == 2, 0);
    cyc(0, 0, 0, 1, 0);

    // R6: fill the remaining slots
    for (int i = 0; i < 700 && m_idx >= 0; i++)
      cyc(1, i % 5 == 4, 52'(64'(i) << 12), 1, 0);
    cyc(0, 0, 0, 1, 0);
    chk(log_index === 10'h3FF, "R6 wrapped index", 64'(log_index), 64'h3FF);
    chk(log_full === 1'b0, "R6 not full before need", 64'(log_full), 64'd0);

    // R6/R7: one more fresh event triggers full and stalls
    cyc(1, 0, 52'hC_0FFE_E000_0000, 1, 0);
    chk(log_full === 1'b1, "R6 full raised", 64'(log_full), 64'd1);
    cyc(1, 0, 52'hC_0FFE_E000_0000, 1, 0);
    cyc(1, 0, 52'hC_0FFE_E000_0000, 1, 0);
    chk(ev_ready === 1'b0 && wr_valid === 1'b0, "R7 stalled", 64'(ev_ready), 64'd0);

    // R8: software index reset, held event logged at slot 511
    cyc(1, 0, 52'hC_0FFE_E000_0000, 1, 1);
    chk(log_index === 10'd511 && log_full === 1'b0, "R8 reload", 64'(log_index), 64'd511);
    cyc(1, 0, 52'hC_0FFE_E000_0000, 1, 0);
    chk(wr_addr === ((buf_base & ~64'hFFF) + 64'd4088), "R8 top slot", wr_addr,
        (buf_base & ~64'hFFF) + 64'd4088);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule